// File: doc/BRIEF.md
# Multi-CPU Masked Device Interrupt Distributor

This block gathers device interrupt requests into one shared 64-bit raw request vector and delivers them to four processors. Each processor has its own 64-bit enable mask and its own 64-bit pending vector, and it drives one level-sensitive interrupt line. A line goes high once, when the processor first gets an enabled request. It stays high until a clear strobe leaves that processor's pending vector empty. When a processor's mask is rewritten, its pending vector is rebuilt from the raw requests that the new mask enables.

In front of the distributor sits a small 8-bit legacy interrupt stage. It has a raw vector, a primary enable mask and a secondary mask that is only stored. When its masked requests become active, it posts one fixed bit (bit 55) of the shared request vector. When a legacy clear leaves no enabled legacy request, it clears that bit again. Software writes the masks through a simple write port. Device logic drives post and clear strobes, each carrying a bit vector. A synchronous initialise input returns everything to the empty state.

Top module: `irq_distributor`

## Requirements
- R1: After reset, and one clock after `init` is high, every CPU mask, every pending vector, the raw request vector and all legacy state are zero and every `cpu_irq` bit is 0. `init` overrides any strobe or write in the same cycle.
- R2: A post strobe ORs `post_vec` into the raw request vector. Every CPU whose mask overlaps `post_vec` ORs the whole posted vector into its pending vector and raises its line.
- R3: A CPU whose mask does not overlap a posted vector takes no pending bits and keeps its line low.
- R4: A write to CPU `cpu_mask_idx` stores the mask. If the new mask ANDed with the raw request vector held before this cycle is nonzero, that CPU's pending vector is replaced by the AND and its line is raised. Otherwise its pending vector and line are left as they were.
- R5: A raised CPU line stays high while its pending vector is nonzero. Later posts do not pulse it or change it.
- R6: A clear strobe removes `clr_vec` from the raw vector and from every pending vector. A CPU whose pending vector becomes zero drops its line.
- R7: Within one cycle, mask writes are applied first, then posts, then clears. A bit both posted and cleared in the same cycle ends up clear, both in the raw vector and in every pending vector.
- R8: The legacy stage ORs `leg_post_vec` into its raw vector. On a legacy post, or on a write of the primary mask (`leg_mask_idx` = 0), it posts raw request bit 55 if its raw vector ANDed with its primary mask is nonzero and it is not already asserting.
- R9: A legacy clear strobe removes `leg_clr_vec` from the legacy raw vector. If the masked legacy vector is then zero, bit 55 is cleared as by R6 and the legacy stage stops asserting, so that a later legacy request can post the bit again.
- R10: A write with `leg_mask_idx` = 1 stores the secondary mask and never affects any interrupt line.
- R11: `cpu_irq` is registered. It changes only at the clock edge that follows the strobe or write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous initialise, zeroes all state |
| cpu_mask_wr | input | 1 | CPU mask write enable |
| cpu_mask_idx | input | 2 | Target CPU of the mask write |
| cpu_mask_val | input | 64 | New CPU mask value |
| leg_mask_wr | input | 1 | Legacy mask write enable |
| leg_mask_idx | input | 1 | 0 = primary mask, 1 = secondary mask |
| leg_mask_val | input | 8 | New legacy mask value |
| post_vld | input | 1 | Device post strobe |
| post_vec | input | 64 | Bits to post |
| clr_vld | input | 1 | Device clear strobe |
| clr_vec | input | 64 | Bits to clear |
| leg_post_vld | input | 1 | Legacy post strobe |
| leg_post_vec | input | 8 | Legacy bits to post |
| leg_clr_vld | input | 1 | Legacy clear strobe |
| leg_clr_vec | input | 8 | Legacy bits to clear |
| cpu_irq | output | 4 | Per-CPU level interrupt lines |

## Verification
The routing is tested with posts that hit one CPU, several CPUs, and none. This shows whether the masks are honoured and whether a CPU outside the mask stays quiet. Repeated posts and partial clears to an already-raised CPU show whether the line is kept as a level until its last pending bit is gone. A mask rewrite that keeps only part of the raw requests, followed by a clear of that part, shows whether pending state is rebuilt on the write rather than merged. A post and a clear of the same bit in one cycle show whether the clear takes precedence. The legacy path is driven with enabled and disabled bits, through the secondary mask, and through a full clear followed by a repost. This shows whether bit 55 follows the primary mask only and whether it can be posted again after it has been dropped.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int NCPU_DEF    = 4;
  localparam int VEC_W_DEF   = 64;
  localparam int LEG_W_DEF   = 8;
  localparam int LEG_BIT_DEF = 55;

  // selector of the legacy mask write port
  typedef enum logic {
    LEG_PRI = 1'b0,
    LEG_SEC = 1'b1
  } leg_sel_e;
endpackage

// File: rtl/irq_legacy_ctrl.sv
module irq_legacy_ctrl
  import irq_dist_pkg::*;
#(
  parameter int LEG_W = LEG_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             post_vld,
  input  logic [LEG_W-1:0] post_vec,
  input  logic             clr_vld,
  input  logic [LEG_W-1:0] clr_vec,
  input  logic             mask_wr,
  input  logic             mask_idx,
  input  logic [LEG_W-1:0] mask_val,
  output logic             req_post,
  output logic             req_clr
);
  function automatic logic [LEG_W-1:0] leg_update(
    input logic [LEG_W-1:0] cur, input logic [LEG_W-1:0] setv, input logic [LEG_W-1:0] clrv);
    return (cur | setv) & ~clrv;
  endfunction

  logic [LEG_W-1:0] raw_q, raw_n;
  logic [LEG_W-1:0] mpri_q, mpri_n;
  logic [LEG_W-1:0] msec_q, msec_n;
  logic             flag_q, flag_n;
  logic             pri_wr, sec_wr, masked_nz, trig;

  assign pri_wr = mask_wr && (mask_idx == LEG_PRI);
  assign sec_wr = mask_wr && (mask_idx == LEG_SEC);

  always_comb begin
    raw_n  = leg_update(raw_q, post_vld ? post_vec : '0, clr_vld ? clr_vec : '0);
    mpri_n = pri_wr ? mask_val : mpri_q;
    msec_n = sec_wr ? mask_val : msec_q;
    if (init) begin
      raw_n  = '0;
      mpri_n = '0;
      msec_n = '0;
    end
  end

  assign masked_nz = |(raw_n & mpri_n);
  assign trig      = post_vld || pri_wr;
  assign req_post  = !init && trig && masked_nz && !flag_q;
  assign req_clr   = !init && clr_vld && !masked_nz;

  always_comb begin
    flag_n = flag_q;
    if (req_post)      flag_n = 1'b1;
    else if (req_clr)  flag_n = 1'b0;
    if (init)          flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mpri_q <= '0;
      msec_q <= '0;
      flag_q <= 1'b0;
    end else begin
      raw_q  <= raw_n;
      mpri_q <= mpri_n;
      msec_q <= msec_n;
      flag_q <= flag_n;
    end
  end

  // a legacy post is only issued after a post strobe or a primary mask write
  p_leg_post_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(trig));
  // the stage stops asserting only on a legacy clear or an initialise
  p_leg_drop_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_vld || init));
  // secondary mask holds the written value and nothing else
  p_sec_mask_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_wr && !init) |-> (msec_q == $past(mask_val)));
endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice
  import irq_dist_pkg::*;
#(
  parameter int VEC_W = VEC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [VEC_W-1:0] raw_cur,
  input  logic [VEC_W-1:0] post_eff,
  input  logic [VEC_W-1:0] clr_eff,
  input  logic             clr_ev,
  input  logic             mask_wr,
  input  logic [VEC_W-1:0] mask_val,
  output logic             irq
);
  function automatic logic [VEC_W-1:0] rebuild(
    input logic [VEC_W-1:0] newmask, input logic [VEC_W-1:0] raw);
    return newmask & raw;
  endfunction

  logic [VEC_W-1:0] mask_q, mask_n;
  logic [VEC_W-1:0] pend_q, pend_n;
  logic [VEC_W-1:0] rb_vec;
  logic             flag_q, flag_n;
  logic             wr_hit, post_hit, raise_ev;

  assign rb_vec   = rebuild(mask_val, raw_cur);
  assign wr_hit   = mask_wr && (rb_vec != '0);
  assign mask_n   = init ? '0 : (mask_wr ? mask_val : mask_q);
  assign post_hit = |(post_eff & mask_n);
  assign raise_ev = !init && (wr_hit || post_hit);

  always_comb begin
    pend_n = pend_q;
    flag_n = flag_q;
    if (wr_hit) begin
      pend_n = rb_vec;
      flag_n = 1'b1;
    end
    if (post_hit) begin
      pend_n = pend_n | post_eff;
      flag_n = 1'b1;
    end
    pend_n = pend_n & ~clr_eff;
    if (clr_ev && (pend_n == '0)) flag_n = 1'b0;
    if (init) begin
      pend_n = '0;
      flag_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      flag_q <= 1'b0;
    end else begin
      mask_q <= mask_n;
      pend_q <= pend_n;
      flag_q <= flag_n;
    end
  end

  assign irq = flag_q;

  // line level matches non-empty pending state
  p_flag_tracks_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q == (pend_q != '0));
  // a rise is caused by a raise event in the previous cycle
  p_rise_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(raise_ev));
  // a drop needs a clear event or initialise in the previous cycle
  p_drop_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_ev || init));
  // a raised line with no clear stays raised
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_ev && !init) |=> flag_q);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int NCPU    = NCPU_DEF,
  parameter int VEC_W   = VEC_W_DEF,
  parameter int LEG_W   = LEG_W_DEF,
  parameter int LEG_BIT = LEG_BIT_DEF,
  localparam int CPU_IDX_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic                 cpu_mask_wr,
  input  logic [CPU_IDX_W-1:0] cpu_mask_idx,
  input  logic [VEC_W-1:0]     cpu_mask_val,
  input  logic                 leg_mask_wr,
  input  logic                 leg_mask_idx,
  input  logic [LEG_W-1:0]     leg_mask_val,
  input  logic                 post_vld,
  input  logic [VEC_W-1:0]     post_vec,
  input  logic                 clr_vld,
  input  logic [VEC_W-1:0]     clr_vec,
  input  logic                 leg_post_vld,
  input  logic [LEG_W-1:0]     leg_post_vec,
  input  logic                 leg_clr_vld,
  input  logic [LEG_W-1:0]     leg_clr_vec,
  output logic [NCPU-1:0]      cpu_irq
);
  localparam logic [VEC_W-1:0] LEG_ONEHOT = {{(VEC_W-1){1'b0}}, 1'b1} << LEG_BIT;

  function automatic logic [VEC_W-1:0] merge(
    input logic en, input logic [VEC_W-1:0] v, input logic leg, input logic [VEC_W-1:0] legv);
    return (en ? v : '0) | (leg ? legv : '0);
  endfunction

  logic             leg_post, leg_clr, clr_ev;
  logic [VEC_W-1:0] post_eff, clr_eff;
  logic [VEC_W-1:0] raw_q, raw_n;

  irq_legacy_ctrl #(.LEG_W(LEG_W)) u_leg (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (init),
    .post_vld (leg_post_vld),
    .post_vec (leg_post_vec),
    .clr_vld  (leg_clr_vld),
    .clr_vec  (leg_clr_vec),
    .mask_wr  (leg_mask_wr),
    .mask_idx (leg_mask_idx),
    .mask_val (leg_mask_val),
    .req_post (leg_post),
    .req_clr  (leg_clr)
  );

  assign post_eff = merge(post_vld, post_vec, leg_post, LEG_ONEHOT);
  assign clr_eff  = merge(clr_vld, clr_vec, leg_clr, LEG_ONEHOT);
  assign clr_ev   = clr_vld || leg_clr;
  assign raw_n    = init ? '0 : ((raw_q | post_eff) & ~clr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_n;
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic wr_sel;
    assign wr_sel = cpu_mask_wr && (cpu_mask_idx == CPU_IDX_W'(i));
    irq_cpu_slice #(.VEC_W(VEC_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (init),
      .raw_cur  (raw_q),
      .post_eff (post_eff),
      .clr_eff  (clr_eff),
      .clr_ev   (clr_ev),
      .mask_wr  (wr_sel),
      .mask_val (cpu_mask_val),
      .irq      (cpu_irq[i])
    );
  end

  // initialise leaves everything quiet
  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init) |-> (cpu_irq == '0 && raw_q == '0));
  // a cleared bit is absent from the raw vector afterwards
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_vld) |-> ((raw_q & $past(clr_vec)) == '0));
  // legacy stage never posts and clears its bit together
  p_leg_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg_post && leg_clr));
endmodule

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic        cpu_mask_wr = 1'b0;
  logic [1:0]  cpu_mask_idx = '0;
  logic [63:0] cpu_mask_val = '0;
  logic        leg_mask_wr = 1'b0;
  logic        leg_mask_idx = 1'b0;
  logic [7:0]  leg_mask_val = '0;
  logic        post_vld = 1'b0;
  logic [63:0] post_vec = '0;
  logic        clr_vld = 1'b0;
  logic [63:0] clr_vec = '0;
  logic        leg_post_vld = 1'b0;
  logic [7:0]  leg_post_vec = '0;
  logic        leg_clr_vld = 1'b0;
  logic [7:0]  leg_clr_vec = '0;
  logic [3:0]  cpu_irq;

  irq_distributor dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] last_exp = '0;

  // reference state
  logic [63:0] m_raw = '0;
  logic [63:0] m_mask[4];
  logic [63:0] m_pend[4];
  logic [3:0]  m_line = '0;
  logic [7:0]  l_raw = '0, l_pri = '0, l_sec = '0;
  logic        l_on = 1'b0;

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cpu_irq actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0]  nl;
    logic [7:0]  npri;
    logic        hit, lp, lc;
    logic [63:0] pv, cv;
    nl   = (l_raw | (leg_post_vld ? leg_post_vec : 8'h0)) & ~(leg_clr_vld ? leg_clr_vec : 8'h0);
    npri = (leg_mask_wr && !leg_mask_idx) ? leg_mask_val : l_pri;
    hit  = (nl & npri) != 8'h0;
    lp   = !init && hit && !l_on && (leg_post_vld || (leg_mask_wr && !leg_mask_idx));
    lc   = !init && !hit && leg_clr_vld;
    pv   = post_vld ? post_vec : 64'h0;
    cv   = clr_vld ? clr_vec : 64'h0;
    if (lp) pv[55] = 1'b1;
    if (lc) cv[55] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic        wr;
      logic [63:0] mk;
      logic [63:0] pd;
      logic        on;
      wr = cpu_mask_wr && (cpu_mask_idx == 2'(i));
      mk = wr ? cpu_mask_val : m_mask[i];
      pd = m_pend[i];
      on = m_line[i];
      if (wr && ((cpu_mask_val & m_raw) != 64'h0)) begin pd = cpu_mask_val & m_raw; on = 1'b1; end
      if ((pv & mk) != 64'h0) begin pd = pd | pv; on = 1'b1; end
      pd = pd & ~cv;
      if ((clr_vld || lc) && pd == 64'h0) on = 1'b0;
      if (init) begin mk = '0; pd = '0; on = 1'b0; end
      m_mask[i] = mk; m_pend[i] = pd; m_line[i] = on;
    end
    m_raw = init ? 64'h0 : ((m_raw | pv) & ~cv);
    if (init) begin l_raw = '0; l_pri = '0; l_sec = '0; l_on = 1'b0; end
    else begin
      if (leg_mask_wr && leg_mask_idx) l_sec = leg_mask_val;
      l_raw = nl; l_pri = npri;
      if (lp) l_on = 1'b1; else if (lc) l_on = 1'b0;
    end
  endtask

  // driver: inputs already set; checks no early change, steps the model, pushes the expected value
  task automatic cycle(input string tag);
    #1 chk("R11 pre-edge", cpu_irq, last_exp);
    model_step();
    @(posedge clk);
    #2;
    init = 0; cpu_mask_wr = 0; leg_mask_wr = 0; post_vld = 0; clr_vld = 0;
    leg_post_vld = 0; leg_clr_vld = 0;
    exp_q.push_back(m_line);
    tag_q.push_back(tag);
    last_exp = m_line;
  endtask

  task automatic wr_cpu(input int idx, input logic [63:0] v);
    cpu_mask_wr = 1; cpu_mask_idx = 2'(idx); cpu_mask_val = v;
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, cpu_irq, e);
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_mask[i] = '0; m_pend[i] = '0; end
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    chk("R1 reset", cpu_irq, 4'b0000);
    wr_cpu(0, 64'h3);                     cycle("R4 mask no raw");
    wr_cpu(1, 64'h100);                   cycle("R4 mask no raw");
    wr_cpu(2, 64'h1 << 55);               cycle("R4 mask no raw");
    post_vld = 1; post_vec = 64'h1;       cycle("R2 post one cpu R3 others low");
    post_vld = 1; post_vec = 64'h2;       cycle("R5 repost held");
    post_vld = 1; post_vec = (64'h1 << 40) | 64'h100; cycle("R2 second cpu");
    clr_vld = 1; clr_vec = 64'h1;         cycle("R6 partial clear keeps line");
    clr_vld = 1; clr_vec = 64'h2;         cycle("R6 last bit drops line");
    wr_cpu(3, 64'h1 << 40);               cycle("R4 mask hits raw");
    wr_cpu(1, 64'h1 << 40);               cycle("R4 rebuild on write");
    clr_vld = 1; clr_vec = 64'h1 << 40;   cycle("R4 rebuilt pending emptied");
    wr_cpu(0, 64'h1 << 20);               cycle("R4 mask zero overlap");
    post_vld = 1; post_vec = 64'h1 << 20; clr_vld = 1; clr_vec = 64'h1 << 20; cycle("R7 same cycle");
    wr_cpu(0, 64'h1 << 20);               cycle("R7 raw bit cleared");
    leg_post_vld = 1; leg_post_vec = 8'h04; cycle("R8 unmasked legacy");
    leg_mask_wr = 1; leg_mask_idx = 1; leg_mask_val = 8'h04; cycle("R10 secondary inert");
    leg_mask_wr = 1; leg_mask_idx = 0; leg_mask_val = 8'h04; cycle("R8 primary mask posts");
    leg_post_vld = 1; leg_post_vec = 8'h08; cycle("R8 legacy held");
    leg_clr_vld = 1; leg_clr_vec = 8'h08;   cycle("R9 legacy still active");
    leg_clr_vld = 1; leg_clr_vec = 8'h04;   cycle("R9 legacy cleared");
    leg_post_vld = 1; leg_post_vec = 8'h04; cycle("R8 legacy repost");
    wr_cpu(1, 64'h100); post_vld = 1; post_vec = 64'h100; cycle("R2 two lines");
    init = 1; post_vld = 1; post_vec = 64'h100; cycle("R1 init overrides");
    wr_cpu(1, 64'h100);                   cycle("R1 raw empty after init");
    leg_post_vld = 1; leg_post_vec = 8'h04; cycle("R1 legacy mask zero after init");
    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule